// File: doc/BRIEF.md
# FIFO Trigger and DMA Ready Generator

This block sits beside the transmit and receive FIFOs of one serial channel and turns their fill counts into two DMA request lines, a transmit-ready and a receive-ready, plus two level conditions that the interrupt logic can use. Each request line comes from its own two-state machine. The receive side also contains an idle timer. The timer counts character-time ticks while received data sits unread, and it raises a time-out indication after four character times without activity.

There are two signalling schemes. In single-transfer mode (mode 0), the transmit request follows an empty transmit FIFO and the receive request follows a non-empty receive FIFO. In block mode (mode 1), each request line has hysteresis. The transmit request sets once enough free space exists and stays set until the FIFO is full. The receive request sets on reaching the trigger level or on a time-out, and stays set until the FIFO is empty.

Each direction's trigger level comes from a 4-bit programmable field scaled by four. When that field is zero, a two-bit fixed selection supplies the level instead.

The transmit machine has two states. REQ_IDLE moves to REQ_ON when the free space meets the level, and REQ_ON moves back to REQ_IDLE when the FIFO is full. The receive machine uses the same two states. REQ_IDLE moves to REQ_ON on reaching the level or on a time-out, and REQ_ON moves back to REQ_IDLE when the FIFO is empty. In mode 0 both machines load the state straight from the fill condition.

The idle timer has three states. TMR_OFF moves to TMR_RUN when the receive FIFO is not empty. TMR_RUN moves to TMR_FIRED on the fourth tick. TMR_FIRED moves back to TMR_RUN on a receive or a read. Any state moves to TMR_OFF when the receive FIFO is empty.

Top module: `fifo_dma_ready`

## Requirements
- R1: While reset is active, tx_rdy, rx_rdy and rx_timeout are 0.
- R2: Each direction's level is 4 times its programmable field when that field is non-zero. When the field is zero, the fixed selection gives the level: TX selections 0..3 give 8, 16, 32, 56 and RX selections 0..3 give 8, 16, 56, 60. tx_lvl_hit is (64 - tx_fill) >= TX level and rx_lvl_hit is rx_fill >= RX level, both without delay.
- R3: Block mode (mode 1) applies only when fifo_en=1 and dma_blk=1; every other combination behaves as mode 0.
- R4: In mode 0, tx_rdy is 1 in the cycle after a clock edge that sampled tx_fill==0, and 0 otherwise.
- R5: In mode 0, rx_rdy is 1 in the cycle after a clock edge that sampled rx_fill!=0, and 0 otherwise.
- R6: In mode 1, tx_rdy sets one clock after free space (64 - tx_fill) is at least the TX level. It then holds until an edge samples tx_fill==64, which clears it one clock later. It stays clear until the level condition holds again.
- R7: In mode 1, rx_rdy sets one clock after rx_fill reaches the RX level, or one clock after rx_timeout is 1. It holds until an edge samples rx_fill==0, which clears it one clock later.
- R8: The idle timer counts char_tick pulses while the receive FIFO is not empty. rx_push or rx_pop restarts the count, and a restart wins over a tick in the same cycle. rx_timeout becomes 1 the clock after the fourth counted tick and stays 1 until a restart.
- R9: An edge that samples rx_fill==0 stops the timer and clears rx_timeout one clock later. The first non-empty edge after that only starts the timer, and a tick in that same cycle is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | FIFOs enabled |
| dma_blk | input | 1 | 1 selects block DMA signalling |
| tx_fill | input | 7 | Transmit FIFO fill count, 0..64 |
| rx_fill | input | 7 | Receive FIFO fill count, 0..64 |
| tx_prog | input | 4 | Programmable TX level field (units of 4) |
| rx_prog | input | 4 | Programmable RX level field (units of 4) |
| tx_fix_sel | input | 2 | Fixed TX level selection |
| rx_fix_sel | input | 2 | Fixed RX level selection |
| char_tick | input | 1 | One pulse per character time |
| rx_push | input | 1 | A character entered the RX FIFO |
| rx_pop | input | 1 | A read of the RX FIFO |
| tx_rdy | output | 1 | Transmit DMA request |
| rx_rdy | output | 1 | Receive DMA request |
| tx_lvl_hit | output | 1 | TX free space at or above level |
| rx_lvl_hit | output | 1 | RX fill at or above level |
| rx_timeout | output | 1 | Receive idle time-out |

## Verification
Two cases can fall in the same cycle.

The first is a timer restart (rx_push or rx_pop) landing on the same cycle as char_tick. The bench drives both on one edge, either partway through a count or while the time-out is already active. The tick must be lost: the time-out must come four fresh ticks later, or must drop.

The second is an emptying receive FIFO landing on the same cycle as a time-out that is setting the block-mode request. The bench empties the FIFO exactly when rx_timeout rises. A behavioural model checks rx_rdy on every clock, so the bench judges whether emptying wins.

// File: rtl/fdr_pkg.sv
package fdr_pkg;

    typedef enum logic {
        REQ_IDLE = 1'b0,
        REQ_ON   = 1'b1
    } req_state_e;

    typedef enum logic [1:0] {
        TMR_OFF   = 2'd0,
        TMR_RUN   = 2'd1,
        TMR_FIRED = 2'd2
    } tmr_state_e;

    // Fixed level used when the programmable field is zero
    function automatic int unsigned fixed_level(input logic is_rx, input logic [1:0] sel);
        int unsigned v;
        if (is_rx) begin
            unique case (sel)
                2'd0: v = 8;
                2'd1: v = 16;
                2'd2: v = 56;
                default: v = 60;
            endcase
        end else begin
            unique case (sel)
                2'd0: v = 8;
                2'd1: v = 16;
                2'd2: v = 32;
                default: v = 56;
            endcase
        end
        return v;
    endfunction

endpackage

// File: rtl/trig_level_pick.sv
module trig_level_pick
    import fdr_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CNT_W = 7,
    parameter int TLR_W = 4,
    parameter int GRAN  = 4,
    parameter bit IS_RX = 1'b0
) (
    input  logic [TLR_W-1:0] prog_field,
    input  logic [1:0]       fix_sel,
    input  logic [CNT_W-1:0] fill,
    output logic [CNT_W-1:0] level,
    output logic             hit
);

    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    always_comb begin
        if (prog_field != '0) begin
            level = CNT_W'(int'(prog_field) * GRAN);
        end else begin
            level = CNT_W'(fixed_level(IS_RX, fix_sel));
        end
    end

    generate
        if (IS_RX) begin : g_rx
            assign hit = (fill >= level);
        end else begin : g_tx
            assign hit = ((FULL - fill) >= level);
        end
    endgenerate

endmodule

// File: rtl/tx_ready_fsm.sv
module tx_ready_fsm
    import fdr_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             blk_mode,
    input  logic [CNT_W-1:0] fill,
    input  logic             lvl_hit,
    output logic             rdy
);

    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    req_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= REQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (!blk_mode) begin
            state_d = (fill == '0) ? REQ_ON : REQ_IDLE;
        end else begin
            unique case (state_q)
                REQ_IDLE: if (lvl_hit && fill != FULL) state_d = REQ_ON;
                REQ_ON:   if (fill == FULL)            state_d = REQ_IDLE;
                default:  state_d = REQ_IDLE;
            endcase
        end
    end

    always_comb rdy = (state_q == REQ_ON);

    // R6: a full FIFO drops the block-mode request
    p_tx_full_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_mode && fill == FULL) |=> !rdy);

    // R4: single-transfer mode follows an empty FIFO
    p_tx_empty_m0_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!blk_mode && fill == '0) |=> rdy);

endmodule

// File: rtl/rx_ready_fsm.sv
module rx_ready_fsm
    import fdr_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             blk_mode,
    input  logic [CNT_W-1:0] fill,
    input  logic             lvl_hit,
    input  logic             timeout,
    output logic             rdy
);

    req_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= REQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (!blk_mode) begin
            state_d = (fill != '0) ? REQ_ON : REQ_IDLE;
        end else begin
            unique case (state_q)
                REQ_IDLE: if (fill != '0 && (lvl_hit || timeout)) state_d = REQ_ON;
                REQ_ON:   if (fill == '0)                         state_d = REQ_IDLE;
                default:  state_d = REQ_IDLE;
            endcase
        end
    end

    always_comb rdy = (state_q == REQ_ON);

    // R7: an empty FIFO always withdraws the request
    p_rx_empty_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == '0) |=> !rdy);

    // R5: single-transfer mode follows a non-empty FIFO
    p_rx_data_m0_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!blk_mode && fill != '0) |=> rdy);

endmodule

// File: rtl/rx_idle_timer.sv
module rx_idle_timer
    import fdr_pkg::*;
#(
    parameter int CNT_W      = 7,
    parameter int IDLE_CHARS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] fill,
    input  logic             tick,
    input  logic             restart,
    output logic             timeout
);

    localparam int TMR_W = $clog2(IDLE_CHARS + 1);
    localparam logic [TMR_W-1:0] LAST = TMR_W'(IDLE_CHARS - 1);

    tmr_state_e state_q, state_d;
    logic [TMR_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TMR_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (fill == '0) begin
            state_d = TMR_OFF;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                TMR_OFF: begin
                    state_d = TMR_RUN;
                    cnt_d   = '0;
                end
                TMR_RUN: begin
                    if (restart) begin
                        cnt_d = '0;
                    end else if (tick) begin
                        if (cnt_q == LAST) begin
                            state_d = TMR_FIRED;
                            cnt_d   = '0;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                TMR_FIRED: begin
                    if (restart) begin
                        state_d = TMR_RUN;
                        cnt_d   = '0;
                    end
                end
                default: begin
                    state_d = TMR_OFF;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    always_comb timeout = (state_q == TMR_FIRED);

    // R9: an empty FIFO clears the time-out
    p_idle_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == '0) |=> !timeout);

    // R8: a restart never leaves the time-out set
    p_idle_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fill != '0 && restart) |=> !timeout);

endmodule

// File: rtl/fifo_dma_ready.sv
module fifo_dma_ready
    import fdr_pkg::*;
#(
    parameter int DEPTH      = 64,
    parameter int TLR_W      = 4,
    parameter int GRAN       = 4,
    parameter int IDLE_CHARS = 4,
    localparam int CNT_W     = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic             dma_blk,
    input  logic [CNT_W-1:0] tx_fill,
    input  logic [CNT_W-1:0] rx_fill,
    input  logic [TLR_W-1:0] tx_prog,
    input  logic [TLR_W-1:0] rx_prog,
    input  logic [1:0]       tx_fix_sel,
    input  logic [1:0]       rx_fix_sel,
    input  logic             char_tick,
    input  logic             rx_push,
    input  logic             rx_pop,
    output logic             tx_rdy,
    output logic             rx_rdy,
    output logic             tx_lvl_hit,
    output logic             rx_lvl_hit,
    output logic             rx_timeout
);

    logic             blk_mode;
    logic [CNT_W-1:0] tx_level;
    logic [CNT_W-1:0] rx_level;

    assign blk_mode = fifo_en & dma_blk;

    trig_level_pick #(
        .DEPTH(DEPTH), .CNT_W(CNT_W), .TLR_W(TLR_W), .GRAN(GRAN), .IS_RX(1'b0)
    ) u_tx_lvl (
        .prog_field(tx_prog), .fix_sel(tx_fix_sel), .fill(tx_fill),
        .level(tx_level), .hit(tx_lvl_hit)
    );

    trig_level_pick #(
        .DEPTH(DEPTH), .CNT_W(CNT_W), .TLR_W(TLR_W), .GRAN(GRAN), .IS_RX(1'b1)
    ) u_rx_lvl (
        .prog_field(rx_prog), .fix_sel(rx_fix_sel), .fill(rx_fill),
        .level(rx_level), .hit(rx_lvl_hit)
    );

    tx_ready_fsm #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_tx_fsm (
        .clk(clk), .rst_n(rst_n), .blk_mode(blk_mode), .fill(tx_fill),
        .lvl_hit(tx_lvl_hit), .rdy(tx_rdy)
    );

    rx_idle_timer #(.CNT_W(CNT_W), .IDLE_CHARS(IDLE_CHARS)) u_idle (
        .clk(clk), .rst_n(rst_n), .fill(rx_fill), .tick(char_tick),
        .restart(rx_push | rx_pop), .timeout(rx_timeout)
    );

    rx_ready_fsm #(.CNT_W(CNT_W)) u_rx_fsm (
        .clk(clk), .rst_n(rst_n), .blk_mode(blk_mode), .fill(rx_fill),
        .lvl_hit(rx_lvl_hit), .timeout(rx_timeout), .rdy(rx_rdy)
    );

    // R3: outside block mode the TX request tracks emptiness only
    p_mode_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!(fifo_en && dma_blk) && tx_fill != '0) |=> !tx_rdy);

    // R2: the resolved RX level stays within 4..60
    p_rx_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level >= CNT_W'(4)) && (rx_level <= CNT_W'(60)));

endmodule

// File: tb/fifo_dma_ready_tb.sv
module fifo_dma_ready_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 64;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       fifo_en, dma_blk;
    logic [6:0] tx_fill, rx_fill;
    logic [3:0] tx_prog, rx_prog;
    logic [1:0] tx_fix_sel, rx_fix_sel;
    logic       char_tick, rx_push, rx_pop;
    logic       tx_rdy, rx_rdy, tx_lvl_hit, rx_lvl_hit, rx_timeout;

    int n_cmp  = 0;
    int n_fail = 0;
    bit done   = 0;

    // reference model state
    bit m_tx, m_rx, m_to, m_run;
    int m_ticks;

    always #(CLK_PERIOD/2) clk = ~clk;

    fifo_dma_ready u_dut (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .dma_blk(dma_blk),
        .tx_fill(tx_fill), .rx_fill(rx_fill), .tx_prog(tx_prog), .rx_prog(rx_prog),
        .tx_fix_sel(tx_fix_sel), .rx_fix_sel(rx_fix_sel), .char_tick(char_tick),
        .rx_push(rx_push), .rx_pop(rx_pop), .tx_rdy(tx_rdy), .rx_rdy(rx_rdy),
        .tx_lvl_hit(tx_lvl_hit), .rx_lvl_hit(rx_lvl_hit), .rx_timeout(rx_timeout)
    );

    function automatic int exp_level(bit is_rx, int field, int sel);
        int tx_tab[4] = '{8, 16, 32, 56};
        int rx_tab[4] = '{8, 16, 56, 60};
        if (field != 0) return field * 4;
        return is_rx ? rx_tab[sel] : tx_tab[sel];
    endfunction

    // behavioural reference, updated on every clock
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_tx = 0; m_rx = 0; m_to = 0; m_run = 0; m_ticks = 0;
        end else begin
            int tl, rl;
            bit blk;
            tl  = exp_level(0, int'(tx_prog), int'(tx_fix_sel));
            rl  = exp_level(1, int'(rx_prog), int'(rx_fix_sel));
            blk = fifo_en && dma_blk;
            if (blk) begin
                if (tx_fill == 7'd64) m_tx = 0;
                else if ((DEPTH - int'(tx_fill)) >= tl) m_tx = 1;
                if (rx_fill == 0) m_rx = 0;
                else if (int'(rx_fill) >= rl || m_to) m_rx = 1;
            end else begin
                m_tx = (tx_fill == 0);
                m_rx = (rx_fill != 0);
            end
            if (rx_fill == 0) begin
                m_run = 0; m_ticks = 0; m_to = 0;
            end else if (!m_run) begin
                m_run = 1; m_ticks = 0; m_to = 0;
            end else if (rx_push || rx_pop) begin
                m_ticks = 0; m_to = 0;
            end else if (char_tick && !m_to) begin
                m_ticks++;
                if (m_ticks == 4) begin m_to = 1; m_ticks = 0; end
            end
        end
    end

    task automatic chk(string what, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", what, act, exp, $time);
        end
    endtask

    // advance one clock and compare all outputs a quarter period later
    task automatic step();
        bit e_tx_hit, e_rx_hit;
        @(posedge clk);
        #(CLK_PERIOD/4);
        e_tx_hit = (DEPTH - int'(tx_fill)) >= exp_level(0, int'(tx_prog), int'(tx_fix_sel));
        e_rx_hit = int'(rx_fill) >= exp_level(1, int'(rx_prog), int'(rx_fix_sel));
        chk("tx_rdy R3 R4 R6", tx_rdy, m_tx);
        chk("rx_rdy R3 R5 R7", rx_rdy, m_rx);
        chk("rx_timeout R8 R9", rx_timeout, m_to);
        chk("tx_lvl_hit R2", tx_lvl_hit, e_tx_hit);
        chk("rx_lvl_hit R2", rx_lvl_hit, e_rx_hit);
    endtask

    task automatic steps(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic pulse_tick();
        char_tick = 1; step(); char_tick = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 0; fifo_en = 0; dma_blk = 0; tx_fill = 0; rx_fill = 0;
        tx_prog = 0; rx_prog = 0; tx_fix_sel = 0; rx_fix_sel = 0;
        char_tick = 0; rx_push = 0; rx_pop = 0;
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/4);
        // R1: reset values
        chk("reset tx_rdy R1", tx_rdy, 1'b0);
        chk("reset rx_rdy R1", rx_rdy, 1'b0);
        chk("reset rx_timeout R1", rx_timeout, 1'b0);
        rst_n = 1;
        steps(2);

        // R2: level resolution sweep, programmable and fixed
        fifo_en = 1;
        for (int f = 0; f < 16; f++) begin
            for (int s = 0; s < 4; s++) begin
                tx_prog = 4'(f); rx_prog = 4'(15 - f);
                tx_fix_sel = 2'(s); rx_fix_sel = 2'(3 - s);
                tx_fill = 7'(f * 4); rx_fill = 7'(60 - f * 3);
                step();
                tx_fill = 7'(64 - f * 4 - 1); rx_fill = 7'(f * 4);
                step();
            end
        end
        rx_fill = 0; tx_fill = 0; tx_prog = 0; rx_prog = 0; steps(2);

        // R4 R5: single-transfer mode patterns
        dma_blk = 0;
        tx_fill = 5; steps(2); tx_fill = 0; steps(2);
        rx_fill = 1; steps(2); rx_fill = 3; steps(2); rx_fill = 0; steps(2);

        // R6: block-mode TX hysteresis, level 16
        dma_blk = 1; tx_prog = 4;
        tx_fill = 64; steps(2);
        tx_fill = 60; steps(2);
        tx_fill = 48; steps(2);
        tx_fill = 60; steps(2);
        tx_fill = 64; steps(2);
        tx_fill = 55; steps(2);
        tx_fill = 40; steps(2);

        // R7 R8: block-mode RX, fixed level 16, time-out sets request
        rx_prog = 0; rx_fix_sel = 1;
        rx_fill = 5; steps(2);
        pulse_tick(); pulse_tick();
        rx_push = 1; char_tick = 1; step(); rx_push = 0; char_tick = 0;
        rx_fill = 6;
        for (int k = 0; k < 5; k++) pulse_tick();
        steps(2);
        rx_pop = 1; char_tick = 1; step(); rx_pop = 0; char_tick = 0;
        rx_fill = 5; steps(2);
        rx_fill = 0; steps(2);
        rx_fill = 20; steps(2);
        rx_fill = 0; steps(2);

        // R9 with R7: empty on the cycle the time-out rises
        rx_fill = 2; char_tick = 1; step(); char_tick = 0; step();
        pulse_tick(); pulse_tick(); pulse_tick();
        char_tick = 1; step(); char_tick = 0;
        rx_fill = 0; steps(3);

        // R3: block bit without FIFOs behaves as mode 0
        fifo_en = 0; dma_blk = 1;
        tx_fill = 30; rx_fill = 2; steps(2);
        tx_fill = 0; steps(2);
        rx_fill = 0; steps(2);
        fifo_en = 1;

        // mixed random traffic
        for (int i = 0; i < 3000; i++) begin
            if (($urandom % 200) == 0) dma_blk = ~dma_blk;
            if (($urandom % 300) == 0) begin
                tx_prog = 4'($urandom); rx_prog = 4'($urandom);
                tx_fix_sel = 2'($urandom); rx_fix_sel = 2'($urandom);
            end
            if (($urandom % 8) == 0) tx_fill = 7'($urandom % 65);
            if (($urandom % 20) == 0) rx_fill = 7'($urandom % 65);
            char_tick = (($urandom % 3) == 0);
            rx_push   = (($urandom % 16) == 0);
            rx_pop    = (($urandom % 16) == 0);
            step();
        end
        char_tick = 0; rx_push = 0; rx_pop = 0;
        steps(2);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

endmodule